// File: doc/BRIEF.md
# I2C Slave Masked Address Matcher

This block makes the acknowledge decision for the address phase of an I2C slave. The serial front end delivers each address byte already assembled, together with a one-cycle strobe and a flag that marks the first byte after a START. The matcher compares the byte with a programmed own-address under a per-bit mask. A clear mask bit makes its address bit a don't-care. A set mask bit demands an exact match. It then reports, one clock later, whether the byte should be acknowledged and which address was matched.

Two slave modes exist. In 7-bit mode a single byte carries the address and the read/write flag. In 10-bit mode a header byte carries a fixed pattern and the two top address bits, and a second byte carries the low eight bits. Only the low byte is subject to the mask.

The mask has no register location of its own. It shares the location of the own-address and is reached only while the mode field holds the configuration code. Software loads it there before it selects a slave mode.

Top module: `i2c_mask_addr_match`

## Requirements
- R1: For every mask bit that is 0, the corresponding address bit is ignored. For every mask bit that is 1, the received bit must equal the own-address bit.
- R2: After reset the mask is all ones, so the comparison is an exact match until a mask is written.
- R3: In 7-bit mode (mode = 4'b0110), on a strobed byte with the first flag set, bits [7:1] of the byte are compared with own-address bits [7:1] under mask bits [7:1]. Byte bit 0 (read/write) never affects the result.
- R4: A write with cfg_sel = 0 updates the mask when mode = 4'b1001 and updates the own-address low byte in any other mode. A write with cfg_sel = 1 stores cfg_wdata[1:0] as the two top bits of the 10-bit own-address, in any mode.
- R5: In 10-bit mode (mode = 4'b0111), a first byte is acknowledged only if its bits [7:3] equal 5'b11110 and its bits [2:1] equal the two top own-address bits. These two bits are never masked, and bit 0 is ignored.
- R6: In 10-bit mode, a byte with the first flag clear is compared as a whole with the own-address low byte under all eight mask bits. It can be acknowledged only if the immediately preceding strobed byte was an accepted header.
- R7: ack_vld is high in the cycle after each byte strobe and low otherwise. ack is registered in the same cycle and is never high without ack_vld. Both outputs and match_addr are 0 after reset.
- R8: In any mode other than 4'b0110 and 4'b0111, including 4'b1001, ack stays 0.
- R9: When ack is high, match_addr holds {3'b000, byte[7:1]} for a 7-bit address, {byte[2:1], 8'h00} for an accepted 10-bit header, and {header[2:1], byte} for an accepted 10-bit low byte.
- R10: In 7-bit mode, with own-address 8'hA0 and mask 8'hF2, exactly the bytes A0h–A1h, A4h–A5h, A8h–A9h and ACh–ADh are acknowledged: eight of the 256 byte values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| mode | input | 4 | Mode field: 0110 7-bit slave, 0111 10-bit slave, 1001 mask access |
| cfg_we | input | 1 | Register write strobe |
| cfg_sel | input | 1 | 0: shared own-address/mask location, 1: top two 10-bit address bits |
| cfg_wdata | input | 8 | Register write data |
| byte_vld | input | 1 | One-cycle strobe for a received address byte |
| byte_first | input | 1 | Byte is the first after START |
| byte_data | input | 8 | Received address byte |
| ack_vld | output | 1 | Decision valid, one cycle after byte_vld |
| ack | output | 1 | Acknowledge the byte |
| match_addr | output | 10 | Address that was matched |

## Verification
The bench builds the block with its default mode codes and the fixed 8-bit byte width. This keeps the full byte space small enough to sweep exhaustively. Every one of the 256 values of the first byte is sent in 7-bit mode under several own-address and mask pairs, including the reset mask, an all-zero mask and the eight-address example. In 10-bit mode every low byte is sent after each of the eight header variants. The expected values are computed arithmetically, which covers both the read/write bit being ignored and the header bits that cannot be masked.

// File: rtl/i2c_mask_addr_match.sv
module i2c_mask_addr_match #(
  parameter logic [3:0] MODE_7B  = 4'b0110,
  parameter logic [3:0] MODE_10B = 4'b0111,
  parameter logic [3:0] MODE_MSK = 4'b1001
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [3:0] mode,
  input  logic       cfg_we,
  input  logic       cfg_sel,
  input  logic [7:0] cfg_wdata,
  input  logic       byte_vld,
  input  logic       byte_first,
  input  logic [7:0] byte_data,
  output logic       ack_vld,
  output logic       ack,
  output logic [9:0] match_addr
);
  localparam logic [4:0] HDR_PAT = 5'b11110;

  logic [7:0] own_lo, mask;
  logic [1:0] own_hi, hdr_hi;
  logic       hdr_ok;
  logic       ack_d;
  logic [9:0] addr_d;

  wire is7  = (mode == MODE_7B);
  wire is10 = (mode == MODE_10B);

  wire hit7    = ((byte_data[7:1] ^ own_lo[7:1]) & mask[7:1]) == 7'd0;
  wire hdr_hit = (byte_data[7:3] == HDR_PAT) && (byte_data[2:1] == own_hi);
  wire lo_hit  = ((byte_data ^ own_lo) & mask) == 8'd0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      own_lo <= 8'h00;
      own_hi <= 2'b00;
      mask   <= 8'hFF;
    end else if (cfg_we) begin
      if (cfg_sel)                own_hi <= cfg_wdata[1:0];
      else if (mode == MODE_MSK)  mask   <= cfg_wdata;
      else                        own_lo <= cfg_wdata;
    end
  end

  always_comb begin
    ack_d  = 1'b0;
    addr_d = match_addr;
    if (is7 && byte_first) begin
      ack_d  = hit7;
      addr_d = {3'b000, byte_data[7:1]};
    end else if (is10 && byte_first) begin
      ack_d  = hdr_hit;
      addr_d = {byte_data[2:1], 8'h00};
    end else if (is10) begin
      ack_d  = hdr_ok && lo_hit;
      addr_d = {hdr_hi, byte_data};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hdr_ok     <= 1'b0;
      hdr_hi     <= 2'b00;
      ack        <= 1'b0;
      ack_vld    <= 1'b0;
      match_addr <= 10'd0;
    end else begin
      ack_vld <= byte_vld;
      ack     <= byte_vld && ack_d;
      if (byte_vld && ack_d) match_addr <= addr_d;
      if (!is10) hdr_ok <= 1'b0;
      else if (byte_vld) begin
        hdr_ok <= byte_first && hdr_hit;
        if (byte_first) hdr_hi <= byte_data[2:1];
      end
    end
  end

  a_r7_ack_needs_vld: assert property (@(posedge clk) disable iff (!rst_n)
    ack |-> ack_vld);

  a_r7_vld_follows_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    ack_vld == $past(byte_vld));

  a_r8_no_ack_outside_slave: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(mode) != MODE_7B && $past(mode) != MODE_10B) |-> !ack);

  a_r4_mask_write_keeps_own: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_we && !cfg_sel && mode == MODE_MSK) |=> $stable(own_lo));

  a_r5_header_exact: assert property (@(posedge clk) disable iff (!rst_n)
    (ack && $past(is10 && byte_vld && byte_first))
      |-> ($past(byte_data[7:3]) == HDR_PAT && $past(byte_data[2:1]) == $past(own_hi)));

  a_r6_low_needs_header: assert property (@(posedge clk) disable iff (!rst_n)
    (ack && $past(is10 && byte_vld && !byte_first)) |-> $past(hdr_ok));
endmodule

// File: tb/tb_i2c_mask_addr_match.sv
module tb_i2c_mask_addr_match;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [3:0] mode = 4'b0000;
  logic       cfg_we = 1'b0, cfg_sel = 1'b0;
  logic [7:0] cfg_wdata = 8'h00;
  logic       byte_vld = 1'b0, byte_first = 1'b0;
  logic [7:0] byte_data = 8'h00;
  logic       ack_vld, ack;
  logic [9:0] match_addr;

  int n_chk = 0, n_bad = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  i2c_mask_addr_match dut (
    .clk(clk), .rst_n(rst_n), .mode(mode), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
    .cfg_wdata(cfg_wdata), .byte_vld(byte_vld), .byte_first(byte_first),
    .byte_data(byte_data), .ack_vld(ack_vld), .ack(ack), .match_addr(match_addr)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic sel, input logic [7:0] d);
    cfg_sel = sel; cfg_wdata = d; cfg_we = 1'b1;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic send(input logic f, input logic [7:0] d);
    byte_first = f; byte_data = d; byte_vld = 1'b1;
    @(negedge clk);
    byte_vld = 1'b0;
  endtask

  task automatic sweep7(input logic [7:0] own, input logic [7:0] msk, input string req,
                        output int hits);
    hits = 0;
    mode = 4'b1001; wr(1'b0, msk);
    mode = 4'b0110; wr(1'b0, own);
    for (int d = 0; d < 256; d++) begin
      logic [7:0] b;
      bit e;
      b = 8'(d);
      e = (((b[7:1] ^ own[7:1]) & msk[7:1]) == 7'd0);
      send(1'b1, b);
      chk(ack_vld == 1'b1, "R7", int'(ack_vld), 1);
      chk(ack == e, req, int'(ack), int'(e));
      if (e) begin
        hits++;
        chk(match_addr == {3'b000, b[7:1]}, "R9", int'(match_addr), int'({3'b000, b[7:1]}));
      end
    end
  endtask

  initial begin
    int h;
    repeat (3) @(negedge clk);
    chk(ack == 0 && ack_vld == 0 && match_addr == 0, "R7", int'({ack, ack_vld, match_addr}), 0);
    rst_n = 1'b1;
    @(negedge clk);

    // R2: reset mask gives exact compare; R3: bit 0 ignored
    mode = 4'b0110; wr(1'b0, 8'hA0);
    for (int d = 0; d < 256; d++) begin
      logic [7:0] b;
      b = 8'(d);
      send(1'b1, b);
      chk(ack == (b[7:1] == 7'h50), "R2", int'(ack), int'(b[7:1] == 7'h50));
    end

    // R8: mask-access mode never acknowledges
    mode = 4'b1001; wr(1'b0, 8'hF2);
    send(1'b1, 8'hA0);
    chk(ack == 1'b0, "R8", int'(ack), 0);
    chk(ack_vld == 1'b1, "R7", int'(ack_vld), 1);
    mode = 4'b0000; send(1'b1, 8'hA0);
    chk(ack == 1'b0, "R8", int'(ack), 0);

    // R4: mask write kept own-address A0; R10 example
    mode = 4'b0110;
    send(1'b1, 8'hA4);
    chk(ack == 1'b1, "R4", int'(ack), 1);
    sweep7(8'hA0, 8'hF2, "R10", h);
    chk(h == 8, "R10", h, 8);
    sweep7(8'h6E, 8'hFE, "R1", h);
    chk(h == 2, "R1", h, 2);
    sweep7(8'h33, 8'h00, "R1", h);
    chk(h == 256, "R1", h, 256);
    sweep7(8'h5A, 8'h0E, "R3", h);
    chk(h == 32, "R3", h, 32);
    sweep7(8'hC4, 8'hE0, "R1", h);
    chk(h == 32, "R1", h, 32);

    // R7: idle cycle after a strobe
    @(negedge clk);
    chk(ack_vld == 1'b0 && ack == 1'b0, "R7", int'({ack_vld, ack}), 0);

    // 10-bit mode
    mode = 4'b1001; wr(1'b0, 8'hF0);
    mode = 4'b0111; wr(1'b1, 8'h02); wr(1'b0, 8'h5A);
    for (int hb = 0; hb < 4; hb++) begin
      for (int rw = 0; rw < 2; rw++) begin
        for (int d = 0; d < 256; d++) begin
          logic [7:0] hdr, b;
          bit eh, el;
          hdr = {5'b11110, 2'(hb), 1'(rw)};
          b = 8'(d);
          eh = (hb == 2);
          el = eh && (((b ^ 8'h5A) & 8'hF0) == 8'h00);
          send(1'b1, hdr);
          chk(ack == eh, "R5", int'(ack), int'(eh));
          if (eh) chk(match_addr == {2'(hb), 8'h00}, "R9", int'(match_addr), int'({2'(hb), 8'h00}));
          send(1'b0, b);
          chk(ack == el, "R6", int'(ack), int'(el));
          if (el) chk(match_addr == {2'(hb), b}, "R9", int'(match_addr), int'({2'(hb), b}));
        end
      end
    end
    send(1'b1, 8'hE4);
    chk(ack == 1'b0, "R5", int'(ack), 0);
    send(1'b0, 8'h5A);
    chk(ack == 1'b0, "R6", int'(ack), 0);
    send(1'b1, 8'hF4);
    send(1'b0, 8'h5A);
    chk(ack == 1'b1, "R6", int'(ack), 1);
    send(1'b0, 8'h5A);
    chk(ack == 1'b0, "R6", int'(ack), 0);

    // R5: all-zero mask still needs the top bits
    mode = 4'b1001; wr(1'b0, 8'h00);
    mode = 4'b0111;
    send(1'b1, 8'hF2);
    chk(ack == 1'b0, "R5", int'(ack), 0);
    send(1'b0, 8'h5A);
    chk(ack == 1'b0, "R5", int'(ack), 0);
    send(1'b1, 8'hF5);
    chk(ack == 1'b1, "R5", int'(ack), 1);
    send(1'b0, 8'h00);
    chk(ack == 1'b1 && match_addr == 10'h200, "R1", int'(match_addr), 'h200);

    if (!done) begin
      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule